// File: doc/BRIEF.md
# Mirrored-Counter Instruction Fetch Link

This block joins a processor's instruction fetch path to an external program store over a narrow shared bus. It has two cooperating halves. The processor half keeps a slave program counter. The store half keeps its own mirror counter, which indexes an 8 KB program window. The two counters are updated by the same bus strobes, so they always hold the same value.

A full address crosses the bus only after reset and after each jump. An address load takes two 8-bit beats, low byte first, both marked by an address strobe. Every other transfer is a fetch beat. In a fetch beat the store half drives the byte at its mirror counter onto the bus, the processor half captures it, and both counters step by one.

A jump that arrives together with a fetch beat lets that beat finish: both counters still step. The byte from that beat is thrown away, and the two address beats for the jump target follow. Addresses outside the store window still load and advance the mirror counter. For those addresses the store does not drive the bus and no byte is delivered.

Top module: `mirror_fetch_link`

## Requirements
- R1: While reset is held, both counters read 0, `fetch_ready` is low and `instr_valid` is low. The first two cycles after reset are address beats, and each carries 0x00.
- R2: An address load is two consecutive cycles with `bus_addr_stb` high. `bus_data` carries target bits [7:0] in the first beat and bits [15:8] in the second. In the cycle after the second beat, `fetch_ready` is high and both counters equal the target.
- R3: A fetch beat is a cycle with `fetch_ready` and `fetch_req` high. It raises `bus_fetch_stb`. For an in-window counter value p, the beat drives `mem_addr` = p[12:0], and `bus_data` and `bus_ack` show the store byte. In the next cycle `instr_valid` is high and `instr_byte` holds that byte.
- R4: Each fetch beat advances `cpu_pc` and `mem_pc` by exactly one. Cycles without a beat leave them unchanged, and the two are equal in every cycle.
- R5: `bus_addr_stb` is high only in the two beats after reset and the two beats after each accepted jump. A run of sequential fetches never raises it.
- R6: A `jump_req` in the same cycle as a fetch beat lets the beat complete, so both counters step by one. `instr_valid` stays low in the next cycle, and the address load of the new target follows.
- R7: A counter value whose bits [15:13] differ from those of `WIN_BASE` is outside the store window. A fetch beat at such a value leaves `bus_ack` and `mem_en` low, the bus idles at 0xFF, and `instr_valid` stays low in the next cycle. The counters still advance.
- R8: While `fetch_ready` is low, `fetch_req` and `jump_req` are ignored. No fetch beat occurs, and the address being loaded is not replaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_req | input | 1 | Processor asks for the next instruction byte |
| jump_req | input | 1 | Processor takes a jump to `jump_target` |
| jump_target | input | 16 | Jump destination address |
| fetch_ready | output | 1 | Link is in the run phase; requests are accepted |
| instr_valid | output | 1 | `instr_byte` holds a freshly delivered byte |
| instr_byte | output | 8 | Last delivered instruction byte |
| cpu_pc | output | 16 | Slave program counter |
| mem_pc | output | 16 | Mirror counter of the store side |
| bus_data | output | 8 | Value on the shared bus (0xFF when idle) |
| bus_addr_stb | output | 1 | Address-beat strobe |
| bus_fetch_stb | output | 1 | Fetch-beat strobe |
| bus_ack | output | 1 | Store side drives data in this fetch beat |
| mem_addr | output | 13 | Program store read address |
| mem_en | output | 1 | Program store read enable |
| mem_rdata | input | 8 | Program store read data |

## Verification
A long unbroken run of back-to-back fetches from the window base checks that the data-only beats keep both counters in step. That run must also raise no address strobe. Gapped fetch patterns separate stepping on a beat from stepping on every cycle. A sweep of jump targets includes one that runs over the top edge of the window and ones that start below it, which separates the window decode from the data path. Jumps that coincide with a beat, together with requests made during the address beats, show that the in-flight beat completes, its byte is discarded, and the address load cannot be disturbed. A final count of address beats confirms they came only from start-up and jumps.

// File: rtl/mfl_pkg.sv
package mfl_pkg;
    typedef enum logic [1:0] {
        LINK_LOAD_LO = 2'd0,
        LINK_LOAD_HI = 2'd1,
        LINK_RUN     = 2'd2
    } link_state_e;
endpackage

// File: rtl/mfl_cpu_side.sv
module mfl_cpu_side
    import mfl_pkg::*;
#(
    parameter int BUS_W = 8,
    localparam int ADDR_W = 2 * BUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic              jump_req,
    input  logic [ADDR_W-1:0] jump_target,
    input  logic [BUS_W-1:0]  bus_in,
    input  logic              bus_ack,
    output logic              drv_en,
    output logic [BUS_W-1:0]  drv_data,
    output logic              addr_stb,
    output logic              fetch_stb,
    output logic              ready,
    output logic [ADDR_W-1:0] pc,
    output logic              ivalid,
    output logic [BUS_W-1:0]  ibyte
);
    typedef struct packed {
        link_state_e       st;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] tgt;
        logic [BUS_W-1:0]  ibyte;
        logic              ivalid;
    } cpu_regs_t;

    cpu_regs_t cur_q, cur_d;

    always_comb begin
        cur_d        = cur_q;
        cur_d.ivalid = 1'b0;
        ready        = (cur_q.st == LINK_RUN);
        addr_stb     = !ready;
        drv_en       = addr_stb;
        drv_data     = (cur_q.st == LINK_LOAD_LO) ? cur_q.tgt[BUS_W-1:0]
                                                  : cur_q.tgt[ADDR_W-1:BUS_W];
        fetch_stb    = ready && fetch_req;
        unique case (cur_q.st)
            LINK_LOAD_LO: cur_d.st = LINK_LOAD_HI;
            LINK_LOAD_HI: begin
                cur_d.st = LINK_RUN;
                cur_d.pc = cur_q.tgt;
            end
            default: begin
                if (fetch_stb) begin
                    cur_d.pc = cur_q.pc + 1'b1;
                    if (bus_ack && !jump_req) begin
                        cur_d.ivalid = 1'b1;
                        cur_d.ibyte  = bus_in;
                    end
                end
                if (jump_req) begin
                    cur_d.tgt = jump_target;
                    cur_d.st  = LINK_LOAD_LO;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.st     <= LINK_LOAD_LO;
            cur_q.pc     <= '0;
            cur_q.tgt    <= '0;
            cur_q.ibyte  <= '0;
            cur_q.ivalid <= 1'b0;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign pc     = cur_q.pc;
    assign ivalid = cur_q.ivalid;
    assign ibyte  = cur_q.ibyte;
endmodule

// File: rtl/mfl_mem_side.sv
module mfl_mem_side #(
    parameter int BUS_W    = 8,
    parameter int STORE_AW = 13,
    localparam int ADDR_W  = 2 * BUS_W,
    parameter logic [ADDR_W-1:0] WIN_BASE = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BUS_W-1:0]    bus_in,
    input  logic                addr_stb,
    input  logic                fetch_stb,
    input  logic [BUS_W-1:0]    mem_rdata,
    output logic                drv_en,
    output logic [BUS_W-1:0]    drv_data,
    output logic [STORE_AW-1:0] mem_addr,
    output logic                mem_en,
    output logic [ADDR_W-1:0]   mirror
);
    typedef struct packed {
        logic [ADDR_W-1:0] mirror;
        logic [BUS_W-1:0]  lo;
        logic              hi_next;
    } mem_regs_t;

    mem_regs_t cur_q, cur_d;
    logic      in_win;

    always_comb begin
        cur_d    = cur_q;
        in_win   = (cur_q.mirror[ADDR_W-1:STORE_AW] == WIN_BASE[ADDR_W-1:STORE_AW]);
        mem_addr = cur_q.mirror[STORE_AW-1:0];
        mem_en   = fetch_stb && in_win;
        drv_en   = mem_en;
        drv_data = mem_en ? mem_rdata : '0;
        if (addr_stb) begin
            cur_d.hi_next = !cur_q.hi_next;
            if (!cur_q.hi_next) cur_d.lo     = bus_in;
            else                cur_d.mirror = {bus_in, cur_q.lo};
        end else if (fetch_stb) begin
            cur_d.mirror = cur_q.mirror + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.mirror  <= '0;
            cur_q.lo      <= '0;
            cur_q.hi_next <= 1'b0;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign mirror = cur_q.mirror;
endmodule

// File: rtl/mfl_bus_mux.sv
module mfl_bus_mux #(
    parameter int BUS_W = 8
) (
    input  logic             cpu_en,
    input  logic [BUS_W-1:0] cpu_data,
    input  logic             mem_en,
    input  logic [BUS_W-1:0] mem_data,
    output logic [BUS_W-1:0] bus
);
    always_comb begin
        if (mem_en)      bus = mem_data;
        else if (cpu_en) bus = cpu_data;
        else             bus = '1;
    end
endmodule

// File: rtl/mirror_fetch_link.sv
module mirror_fetch_link #(
    parameter int BUS_W    = 8,
    parameter int STORE_AW = 13,
    localparam int ADDR_W  = 2 * BUS_W,
    parameter logic [ADDR_W-1:0] WIN_BASE = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fetch_req,
    input  logic                jump_req,
    input  logic [ADDR_W-1:0]   jump_target,
    output logic                fetch_ready,
    output logic                instr_valid,
    output logic [BUS_W-1:0]    instr_byte,
    output logic [ADDR_W-1:0]   cpu_pc,
    output logic [ADDR_W-1:0]   mem_pc,
    output logic [BUS_W-1:0]    bus_data,
    output logic                bus_addr_stb,
    output logic                bus_fetch_stb,
    output logic                bus_ack,
    output logic [STORE_AW-1:0] mem_addr,
    output logic                mem_en,
    input  logic [BUS_W-1:0]    mem_rdata
);
    logic             cpu_drv_en;
    logic [BUS_W-1:0] cpu_drv_data;
    logic             mem_drv_en;
    logic [BUS_W-1:0] mem_drv_data;

    mfl_cpu_side #(.BUS_W(BUS_W)) u_cpu (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_req  (fetch_req),
        .jump_req   (jump_req),
        .jump_target(jump_target),
        .bus_in     (bus_data),
        .bus_ack    (mem_drv_en),
        .drv_en     (cpu_drv_en),
        .drv_data   (cpu_drv_data),
        .addr_stb   (bus_addr_stb),
        .fetch_stb  (bus_fetch_stb),
        .ready      (fetch_ready),
        .pc         (cpu_pc),
        .ivalid     (instr_valid),
        .ibyte      (instr_byte)
    );

    mfl_mem_side #(.BUS_W(BUS_W), .STORE_AW(STORE_AW), .WIN_BASE(WIN_BASE)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_in   (bus_data),
        .addr_stb (bus_addr_stb),
        .fetch_stb(bus_fetch_stb),
        .mem_rdata(mem_rdata),
        .drv_en   (mem_drv_en),
        .drv_data (mem_drv_data),
        .mem_addr (mem_addr),
        .mem_en   (mem_en),
        .mirror   (mem_pc)
    );

    mfl_bus_mux #(.BUS_W(BUS_W)) u_bus (
        .cpu_en  (cpu_drv_en),
        .cpu_data(cpu_drv_data),
        .mem_en  (mem_drv_en),
        .mem_data(mem_drv_data),
        .bus     (bus_data)
    );

    assign bus_ack = mem_drv_en;
endmodule

// File: rtl/mirror_fetch_link_chk.sv
module mirror_fetch_link_chk #(
    parameter int BUS_W = 8,
    localparam int ADDR_W = 2 * BUS_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              jump_req,
    input logic              fetch_ready,
    input logic              instr_valid,
    input logic [BUS_W-1:0]  instr_byte,
    input logic [ADDR_W-1:0] cpu_pc,
    input logic [ADDR_W-1:0] mem_pc,
    input logic [BUS_W-1:0]  bus_data,
    input logic              bus_addr_stb,
    input logic              bus_fetch_stb,
    input logic              bus_ack
);
    a_r4_counters_match: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_pc == mem_pc);

    a_r4_step_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
        bus_fetch_stb |=> mem_pc == $past(mem_pc) + 1'b1);

    a_r5_addr_only_loading: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr_stb |-> !fetch_ready && !bus_fetch_stb);

    a_r2_second_beat: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_addr_stb) |=> bus_addr_stb);

    a_r2_ready_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_addr_stb) |-> fetch_ready);

    a_r3_byte_delivered: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && !jump_req) |=> instr_valid && instr_byte == $past(bus_data));

    a_r6_discard_on_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_fetch_stb && jump_req) |=> !instr_valid);

    a_r7_ack_in_beat: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> bus_fetch_stb);

    a_r7_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_fetch_stb && !bus_ack) |-> bus_data == '1);

    a_r8_no_beat_unready: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_ready |-> !bus_fetch_stb);
endmodule

bind mirror_fetch_link mirror_fetch_link_chk #(.BUS_W(BUS_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .jump_req     (jump_req),
    .fetch_ready  (fetch_ready),
    .instr_valid  (instr_valid),
    .instr_byte   (instr_byte),
    .cpu_pc       (cpu_pc),
    .mem_pc       (mem_pc),
    .bus_data     (bus_data),
    .bus_addr_stb (bus_addr_stb),
    .bus_fetch_stb(bus_fetch_stb),
    .bus_ack      (bus_ack)
);

// File: tb/mirror_fetch_link_bench.sv
module mirror_fetch_link_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fetch_req, jump_req;
    logic [15:0] jump_target;
    logic        fetch_ready, instr_valid;
    logic [7:0]  instr_byte;
    logic [15:0] cpu_pc, mem_pc;
    logic [7:0]  bus_data;
    logic        bus_addr_stb, bus_fetch_stb, bus_ack;
    logic [12:0] mem_addr;
    logic        mem_en;
    logic [7:0]  mem_rdata;

    int          n_chk = 0;
    int          n_fail = 0;
    int          beats_seen = 0;
    int          beats_exp = 0;
    bit          done = 0;
    logic [15:0] exp_pc;

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [7:0] pat(input logic [12:0] a);
        return a[7:0] ^ {a[12:8], 3'b011};
    endfunction

    assign mem_rdata = pat(mem_addr);

    mirror_fetch_link #(.WIN_BASE(16'h2000)) u_mirror_fetch_link (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .jump_req(jump_req),
        .jump_target(jump_target), .fetch_ready(fetch_ready),
        .instr_valid(instr_valid), .instr_byte(instr_byte), .cpu_pc(cpu_pc),
        .mem_pc(mem_pc), .bus_data(bus_data), .bus_addr_stb(bus_addr_stb),
        .bus_fetch_stb(bus_fetch_stb), .bus_ack(bus_ack), .mem_addr(mem_addr),
        .mem_en(mem_en), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) if (rst_n === 1'b1 && bus_addr_stb === 1'b1) beats_seen++;

    task automatic chk(input string req, input bit ok, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Fetch beat at exp_pc; fetch_req is left high for back-to-back use.
    task automatic fetch_one();
        bit inwin;
        fetch_req = 1'b1;
        #1;
        inwin = (exp_pc[15:13] == 3'b001);
        chk("R3 strobe", bus_fetch_stb === 1'b1, bus_fetch_stb, 1);
        chk("R5 no addr in fetch", bus_addr_stb === 1'b0, bus_addr_stb, 0);
        chk("R7 ack", bus_ack === inwin && mem_en === inwin, bus_ack, inwin);
        if (inwin) begin
            chk("R3 mem_addr", mem_addr === exp_pc[12:0], mem_addr, exp_pc[12:0]);
            chk("R3 bus byte", bus_data === pat(exp_pc[12:0]), bus_data, pat(exp_pc[12:0]));
        end else begin
            chk("R7 idle bus", bus_data === 8'hFF, bus_data, 8'hFF);
        end
        step();
        exp_pc = exp_pc + 16'd1;
        chk("R3 valid", instr_valid === inwin, instr_valid, inwin);
        if (inwin)
            chk("R3 byte", instr_byte === pat(16'(exp_pc - 16'd1)), instr_byte,
                pat(16'(exp_pc - 16'd1)));
        chk("R4 cpu_pc", cpu_pc === exp_pc, cpu_pc, exp_pc);
        chk("R4 mem_pc", mem_pc === exp_pc, mem_pc, exp_pc);
    endtask

    task automatic jump_to(input logic [15:0] t, input bit with_beat);
        fetch_req   = with_beat;
        jump_req    = 1'b1;
        jump_target = t;
        #1;
        if (with_beat) chk("R6 beat runs", bus_fetch_stb === 1'b1, bus_fetch_stb, 1);
        step();
        if (with_beat) begin
            exp_pc = exp_pc + 16'd1;
            chk("R6 discard", instr_valid === 1'b0, instr_valid, 0);
            chk("R6 cpu_pc step", cpu_pc === exp_pc, cpu_pc, exp_pc);
            chk("R6 mem_pc step", mem_pc === exp_pc, mem_pc, exp_pc);
        end
        // noise during the address beats (R8)
        fetch_req   = 1'b1;
        jump_req    = 1'b1;
        jump_target = ~t;
        #1;
        chk("R2 lo beat", bus_addr_stb === 1'b1 && bus_data === t[7:0], bus_data, t[7:0]);
        chk("R8 no beat", bus_fetch_stb === 1'b0 && fetch_ready === 1'b0, bus_fetch_stb, 0);
        step();
        chk("R2 hi beat", bus_addr_stb === 1'b1 && bus_data === t[15:8], bus_data, t[15:8]);
        chk("R8 no beat hi", bus_fetch_stb === 1'b0, bus_fetch_stb, 0);
        step();
        fetch_req = 1'b0;
        jump_req  = 1'b0;
        #1;
        chk("R2 ready", fetch_ready === 1'b1 && bus_addr_stb === 1'b0, fetch_ready, 1);
        chk("R2 cpu_pc", cpu_pc === t, cpu_pc, t);
        chk("R8 target kept", mem_pc === t, mem_pc, t);
        chk("R8 no byte", instr_valid === 1'b0, instr_valid, 0);
        exp_pc    = t;
        beats_exp = beats_exp + 2;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; fetch_req = 1'b0; jump_req = 1'b0; jump_target = '0;
        repeat (3) step();
        chk("R1 cpu_pc", cpu_pc === 16'h0, cpu_pc, 0);
        chk("R1 mem_pc", mem_pc === 16'h0, mem_pc, 0);
        chk("R1 not ready", fetch_ready === 1'b0 && instr_valid === 1'b0, fetch_ready, 0);
        rst_n = 1'b1;
        #1;
        chk("R1 vector lo", bus_addr_stb === 1'b1 && bus_data === 8'h00, bus_data, 0);
        step();
        chk("R1 vector hi", bus_addr_stb === 1'b1 && bus_data === 8'h00, bus_data, 0);
        step();
        chk("R1 ready", fetch_ready === 1'b1 && cpu_pc === 16'h0, cpu_pc, 0);
        beats_exp = 2;
        exp_pc    = 16'h0;

        // reset vector lies below the window (R7)
        repeat (3) fetch_one();
        fetch_req = 1'b0;

        // long back-to-back run from the window base (R3, R4, R5)
        jump_to(16'h2000, 1'b0);
        for (int i = 0; i < 300; i++) fetch_one();
        fetch_req = 1'b0;

        // gapped pattern (R4)
        for (int i = 0; i < 45; i++) begin
            if (i % 3 == 0) begin
                fetch_req = 1'b0;
                #1;
                step();
                chk("R4 hold cpu_pc", cpu_pc === exp_pc && mem_pc === exp_pc, cpu_pc, exp_pc);
                chk("R4 no byte idle", instr_valid === 1'b0, instr_valid, 0);
            end else begin
                fetch_one();
            end
        end
        fetch_req = 1'b0;

        // jump sweep, including window edges (R2, R7)
        for (int k = 0; k < 16; k++) begin
            logic [15:0] t;
            case (k)
                12:      t = 16'h3FFE;
                13:      t = 16'h1FFE;
                14:      t = 16'hFFFE;
                15:      t = 16'h4000;
                default: t = 16'(16'h2000 + k * 16'h02A1);
            endcase
            jump_to(t, 1'b0);
            repeat (4) fetch_one();
            fetch_req = 1'b0;
        end

        // jump coinciding with a fetch beat (R6)
        for (int k = 0; k < 6; k++) begin
            jump_to(16'(16'h2100 + k * 16'h0333), 1'b0);
            repeat (k + 1) fetch_one();
            jump_to(16'(16'h2800 + k * 16'h0111), 1'b1);
            repeat (2) fetch_one();
            fetch_req = 1'b0;
        end

        step();
        chk("R5 address beat count", beats_seen == beats_exp, beats_seen, beats_exp);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule